// File: doc/BRIEF.md
# Master domain access checker

This block screens every transaction headed for a flash controller before it is passed on. The screen uses only two properties of the transaction: its 6-bit master ID and whether it carries the secure attribute. The address plays no part. A bank of descriptors holds the rules, and a simple one-cycle write port loads each descriptor. Every descriptor has a valid bit, a reference ID, a 6-bit mask, a mask combining mode and a set of permitted attributes.

A request is allowed when at least one valid descriptor matches its master ID and also permits its attribute. The result is registered. One cycle after the request, the block reports whether the request is allowed and the index of the lowest-numbered descriptor that granted it. A rejected request raises a one-cycle error pulse that carries the offending master ID.

The descriptors come out of reset invalid, so every request is rejected until software loads at least one valid descriptor.

Top module: `domain_access_checker`

## Requirements
- R1: After reset, every descriptor is invalid, in AND mode, with mask 0 and attribute set 0. All outputs are 0, and every request is rejected until a valid descriptor is written.
- R2: A write with `cfg_we_i`=1 loads all fields into descriptor `cfg_idx_i`. The new contents apply to requests presented in the next cycle and after. A request presented in the same cycle as the write is judged on the old contents. A write to an index at or above the descriptor count changes nothing.
- R3: In AND mode (`cfg_or_mode_i`=0), an ID matches when every bit that is 0 in the mask is equal in the ID and the reference. Bits set in the mask are don't-care.
- R4: In OR mode (`cfg_or_mode_i`=1), an ID matches when (ID OR mask) equals the reference exactly. A mask bit that is set where the reference bit is 0 makes the descriptor match nothing.
- R5: Attribute set encoding: 3'b001 permits non-secure requests only, 3'b010 permits secure only, and 3'b011 permits both. Every other code permits nothing. `req_secure_i`=1 marks a secure request.
- R6: A descriptor with its valid bit clear never grants, whatever its other fields hold.
- R7: A request is allowed when any descriptor grants it. `rsp_idx_o` gives the lowest granting index, and it is 0 when the request is rejected.
- R8: `rsp_valid_o` is high exactly one cycle after `req_valid_i`. While `rsp_valid_o` is low, `rsp_allow_o`, `rsp_idx_o`, `err_o` and `err_id_o` are all 0.
- R9: A rejected request raises `err_o` for one cycle together with `rsp_valid_o`, and `err_id_o` equals the request's master ID. An allowed request leaves `err_o` and `err_id_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_idx_i | input | IDX_W | Descriptor index to write |
| cfg_valid_i | input | 1 | Valid bit to write |
| cfg_ref_i | input | 6 | Reference master ID |
| cfg_mask_i | input | 6 | ID mask |
| cfg_or_mode_i | input | 1 | 0 = AND masking, 1 = OR masking |
| cfg_attr_i | input | 3 | Permitted attribute set |
| req_valid_i | input | 1 | Request present |
| req_id_i | input | 6 | Request master ID |
| req_secure_i | input | 1 | Request is secure |
| rsp_valid_o | output | 1 | Result valid |
| rsp_allow_o | output | 1 | Request allowed |
| rsp_idx_o | output | IDX_W | Lowest granting descriptor |
| err_o | output | 1 | Rejection pulse |
| err_id_o | output | 6 | Master ID of rejected request |

## Verification
Every result, including the error pulse and its ID, is due exactly one clock edge after the request. A descriptor write takes effect for requests one edge after the write itself. The bench drives inputs on the falling edge and updates its own descriptor model only after it has computed the expected result for that cycle, so a request that coincides with a write is checked against the old contents. It then samples all outputs on the following falling edge. Directed cases cover mask don't-care bits, the OR-mode dead-descriptor case, reserved attribute codes, invalidation and lowest-index priority. Seeded random traffic follows.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned ID_W   = 6;
  localparam int unsigned ATTR_W = 3;

  localparam logic [ATTR_W-1:0] ATTR_NSEC = 3'b001;
  localparam logic [ATTR_W-1:0] ATTR_SEC  = 3'b010;
  localparam logic [ATTR_W-1:0] ATTR_ANY  = 3'b011;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   ref_id;
    logic [ID_W-1:0]   mask;
    logic              or_mode;
    logic [ATTR_W-1:0] attr;
  } desc_t;
endpackage

// File: rtl/dac_desc_bank.sv
module dac_desc_bank
  import dac_pkg::*;
#(
  parameter int unsigned NUM_DESC = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  desc_t                    wdata_i,
  output desc_t [NUM_DESC-1:0]     desc_o
);
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    desc_t desc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        desc_q <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        desc_q <= wdata_i;
      end
    end
    assign desc_o[g] = desc_q;
  end
endmodule

// File: rtl/dac_desc_match.sv
module dac_desc_match
  import dac_pkg::*;
(
  input  desc_t           desc_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            secure_i,
  output logic            grant_o
);
  logic and_hit, or_hit, id_hit, permit;

  always_comb begin
    and_hit = ((id_i ^ desc_i.ref_id) & ~desc_i.mask) == '0;
    or_hit  = (id_i | desc_i.mask) == desc_i.ref_id;
    id_hit  = desc_i.or_mode ? or_hit : and_hit;
    unique case (desc_i.attr)
      ATTR_NSEC: permit = !secure_i;
      ATTR_SEC:  permit = secure_i;
      ATTR_ANY:  permit = 1'b1;
      default:   permit = 1'b0; // reserved codes grant nothing
    endcase
    grant_o = desc_i.valid && id_hit && permit;
  end
endmodule

// File: rtl/dac_lowest_pick.sv
module dac_lowest_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/domain_access_checker.sv
module domain_access_checker
  import dac_pkg::*;
#(
  parameter  int unsigned NUM_DESC = 8,
  localparam int unsigned IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [ID_W-1:0]   cfg_ref_i,
  input  logic [ID_W-1:0]   cfg_mask_i,
  input  logic              cfg_or_mode_i,
  input  logic [ATTR_W-1:0] cfg_attr_i,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              req_secure_i,
  output logic              rsp_valid_o,
  output logic              rsp_allow_o,
  output logic [IDX_W-1:0]  rsp_idx_o,
  output logic              err_o,
  output logic [ID_W-1:0]   err_id_o
);
  desc_t                wdata;
  desc_t [NUM_DESC-1:0] desc;
  logic  [NUM_DESC-1:0] grant;
  logic                 any_grant;
  logic  [IDX_W-1:0]    pick_idx;
  logic                 allow_d, reject_d;

  assign wdata = '{valid:   cfg_valid_i,
                   ref_id:  cfg_ref_i,
                   mask:    cfg_mask_i,
                   or_mode: cfg_or_mode_i,
                   attr:    cfg_attr_i};

  dac_desc_bank #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (wdata),
    .desc_o  (desc)
  );

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_match
    dac_desc_match u_match (
      .desc_i   (desc[g]),
      .id_i     (req_id_i),
      .secure_i (req_secure_i),
      .grant_o  (grant[g])
    );
  end

  dac_lowest_pick #(.N(NUM_DESC), .IDX_W(IDX_W)) u_pick (
    .req_i (grant),
    .any_o (any_grant),
    .idx_o (pick_idx)
  );

  assign allow_d  = req_valid_i &&  any_grant;
  assign reject_d = req_valid_i && !any_grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_allow_o <= 1'b0;
      rsp_idx_o   <= '0;
      err_o       <= 1'b0;
      err_id_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_allow_o <= allow_d;
      rsp_idx_o   <= allow_d ? pick_idx : '0;
      err_o       <= reject_d;
      err_id_o    <= reject_d ? req_id_i : '0;
    end
  end
endmodule

// File: rtl/dac_checker_sva.sv
module dac_checker_sva
  import dac_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             cfg_valid_i,
  input logic             req_valid_i,
  input logic [ID_W-1:0]  req_id_i,
  input logic             rsp_valid_o,
  input logic             rsp_allow_o,
  input logic [IDX_W-1:0] rsp_idx_o,
  input logic             err_o,
  input logic [ID_W-1:0]  err_id_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (cfg_we_i && cfg_valid_i) seen_q <= 1'b1;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_allow_o && !err_o && rsp_idx_o == '0 && err_id_o == '0)); // R8
  AST_ERR_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (err_o == !rsp_allow_o)); // R9
  AST_ERR_ID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_id_o == $past(req_id_i))); // R9
  AST_IDX_ZERO_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rsp_idx_o == '0)); // R7
  AST_ALLOW_NEEDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_allow_o |-> $past(seen_q)); // R1
endmodule

bind domain_access_checker dac_checker_sva #(.IDX_W(IDX_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_valid_i (cfg_valid_i),
  .req_valid_i (req_valid_i),
  .req_id_i    (req_id_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_allow_o (rsp_allow_o),
  .rsp_idx_o   (rsp_idx_o),
  .err_o       (err_o),
  .err_id_o    (err_id_o)
);

// File: tb/domain_access_checker_bench.sv
module domain_access_checker_bench;
  localparam int ND = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 0, cfg_valid_i = 0, cfg_or_mode_i = 0;
  logic [2:0] cfg_idx_i = 0;
  logic [5:0] cfg_ref_i = 0, cfg_mask_i = 0;
  logic [2:0] cfg_attr_i = 0;
  logic       req_valid_i = 0, req_secure_i = 0;
  logic [5:0] req_id_i = 0;
  logic       rsp_valid_o, rsp_allow_o, err_o;
  logic [2:0] rsp_idx_o;
  logic [5:0] err_id_o;

  int total = 0, bad = 0;

  bit         m_v[ND];
  logic [5:0] m_ref[ND], m_mask[ND];
  bit         m_or[ND];
  logic [2:0] m_attr[ND];

  always #4 clk_i = ~clk_i;

  domain_access_checker u_domain_access_checker (.*);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit permits(input logic [2:0] a, input bit sec);
    if (a == 3'b001) return !sec;
    if (a == 3'b010) return sec;
    if (a == 3'b011) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit id_match(input int d, input logic [5:0] id);
    if (m_or[d]) return (id | m_mask[d]) == m_ref[d];
    return ((id ^ m_ref[d]) & ~m_mask[d]) == 6'd0;
  endfunction

  task automatic step(input bit we, input int idx, input bit v, input logic [5:0] r,
                      input logic [5:0] m, input bit o, input logic [2:0] a,
                      input bit rv, input logic [5:0] rid, input bit rs, input string tag);
    bit e_allow;
    int e_idx;
    cfg_we_i = we; cfg_idx_i = idx[2:0]; cfg_valid_i = v; cfg_ref_i = r;
    cfg_mask_i = m; cfg_or_mode_i = o; cfg_attr_i = a;
    req_valid_i = rv; req_id_i = rid; req_secure_i = rs;
    e_allow = 0; e_idx = 0;
    if (rv) begin
      for (int d = ND - 1; d >= 0; d--) begin
        if (m_v[d] && id_match(d, rid) && permits(m_attr[d], rs)) begin
          e_allow = 1; e_idx = d;
        end
      end
    end
    if (we && idx < ND) begin
      m_v[idx] = v; m_ref[idx] = r; m_mask[idx] = m; m_or[idx] = o; m_attr[idx] = a;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_valid_o == rv, "R8", "rsp_valid", rsp_valid_o, rv);
    chk(rsp_allow_o == e_allow, tag, "allow", rsp_allow_o, e_allow);
    chk(int'(rsp_idx_o) == e_idx, "R7", "idx", rsp_idx_o, e_idx);
    chk(err_o == (rv && !e_allow), "R9", "err", err_o, rv && !e_allow);
    chk(err_id_o == ((rv && !e_allow) ? rid : 6'd0), "R9", "err_id", err_id_o,
        (rv && !e_allow) ? rid : 6'd0);
  endtask

  task automatic wr(input int idx, input bit v, input logic [5:0] r, input logic [5:0] m,
                    input bit o, input logic [2:0] a);
    step(1, idx, v, r, m, o, a, 0, 0, 0, "R2");
  endtask

  task automatic rq(input logic [5:0] rid, input bit rs, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, rid, rs, tag);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R8", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int d = 0; d < ND; d++) begin
      m_v[d] = 0; m_ref[d] = 0; m_mask[d] = 0; m_or[d] = 0; m_attr[d] = 0;
    end
    #1;
    chk(!rsp_valid_o && !rsp_allow_o && !err_o && rsp_idx_o == 0 && err_id_o == 0,
        "R1", "reset outputs", {rsp_valid_o, rsp_allow_o, err_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rq(6'h05, 1, "R1");
    rq(6'h00, 0, "R1");
    // R2: request in the write cycle sees old contents
    step(1, 2, 1, 6'h14, 6'h03, 0, 3'b001, 1, 6'h14, 0, "R2");
    rq(6'h17, 0, "R3");
    rq(6'h18, 0, "R3");
    rq(6'h14, 1, "R5");
    // R4: OR-mode matches
    wr(5, 1, 6'h27, 6'h05, 1, 3'b011);
    rq(6'h22, 1, "R4");
    rq(6'h20, 0, "R4");
    wr(6, 1, 6'h20, 6'h01, 1, 3'b011);
    rq(6'h20, 0, "R4");
    rq(6'h21, 1, "R4");
    // R7: lowest index wins
    wr(1, 1, 6'h14, 6'h03, 0, 3'b011);
    rq(6'h15, 1, "R7");
    rq(6'h15, 0, "R7");
    // R6: invalidated descriptor falls back
    wr(1, 0, 6'h14, 6'h03, 0, 3'b011);
    rq(6'h15, 0, "R6");
    rq(6'h15, 1, "R6");
    // R5: reserved attribute codes
    wr(3, 1, 6'h3F, 6'h00, 0, 3'b111);
    rq(6'h3F, 1, "R5");
    wr(3, 1, 6'h3F, 6'h00, 0, 3'b100);
    rq(6'h3F, 0, "R5");
    wr(3, 1, 6'h3F, 6'h00, 0, 3'b000);
    rq(6'h3F, 0, "R5");
    wr(3, 1, 6'h3F, 6'h00, 0, 3'b010);
    rq(6'h3F, 1, "R5");
    // R8: idle cycles stay quiet
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 6'h2A, 1, "R8");
    for (int n = 0; n < 3000; n++) begin
      bit we;
      we = ($urandom % 4) == 0;
      step(we, $urandom % ND, $urandom % 2, 6'($urandom), 6'($urandom % 64 & ($urandom % 2 ? 6'h3F : 6'h07)),
           $urandom % 2, 3'($urandom), ($urandom % 4) != 0, 6'($urandom), $urandom % 2, "R7");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule